// File: doc/BRIEF.md
# Per-Timeslot Signaling Capture Buffer

The block takes a serial signaling stream clocked one bit per cycle and files it away slot by slot into a 32-entry store, so that entry n always holds the most recent signaling nibble seen in time slot n. A frame sync pulse marks the first bit of slot 0. From that pulse a bit counter and a slot counter address the store directly. No tagging or search takes place. The store holds one multiframe of signaling.

Each time slot is eight bit clocks long. The signaling nibble is the last four bits of the slot, and the first of those four bits received becomes the nibble MSB. The nibble is written at the end of the slot. In E1 mode all 32 slots are captured. In T1 mode only slots 0 to 23 are captured, and the framing bit that follows slot 23 is ignored. A processor port reads any entry combinationally and can overwrite any entry. A processor write wins over a capture to the same entry in the same cycle.

Top module: `sig_capture_buf`

## Requirements
- R1: After reset every entry reads as 0x00.
- R2: The read port returns the addressed entry as {4'b0000, nibble}, so bits 7:4 of the read data are always zero.
- R3: The cycle with frame sync high carries bit 0 of slot 0. Slot n then occupies bits 8n to 8n+7 counted from that cycle, and at most one capture happens in any eight-cycle slot.
- R4: The nibble for a slot is its bits 4..7, with bit 4 as nibble bit 3 and bit 7 as nibble bit 0. During the slot's last bit the entry still reads its old value, and it reads the new value from the following cycle.
- R5: With the mode input high (E1), every frame refreshes entries 0 to 31.
- R6: With the mode input low (T1), a frame refreshes only entries 0 to 23, and entries 24 to 31 keep their values.
- R7: After the last slot of a frame no capture occurs until the next frame sync. No capture occurs between reset and the first frame sync.
- R8: A frame sync arriving mid-frame restarts the count at bit 0 of slot 0, and no capture happens in that cycle.
- R9: A processor write stores bits 3:0 of the write data into the addressed entry, which reads it back from the next cycle on. Bits 7:4 of the write data are dropped.
- R10: If a processor write and a capture hit the same entry in the same cycle, the processor data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one signaling bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Serial signaling data, MSB of each slot first |
| fsync_i | input | 1 | Frame sync, high during bit 0 of slot 0 |
| e1_mode_i | input | 1 | 1 selects 32 slots (E1), 0 selects 24 slots (T1) |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | 5 | Processor entry address (slot number) |
| cpu_wdata_i | input | 8 | Processor write data, bits 3:0 are stored |
| cpu_rdata_o | output | 8 | Addressed entry, upper nibble zero |

## Verification
On every cycle the assertions check four things: the read data upper nibble is zero, T1 captures never address beyond slot 23, captures are never back to back or coincident with frame sync, and a processor write or an uncontested capture shows up on the read port one cycle later. The bench shows what only whole frames can show. It checks the exact bit-to-nibble mapping and slot alignment after sync, and the idle behaviour before the first sync and after the last slot. It also covers the retention of entries 24 to 31 in T1, realignment by an early sync, and the collision outcome at a chosen slot, including the last T1 slot.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;
  parameter int SLOTS     = 32;
  parameter int T1_SLOTS  = 24;
  parameter int SLOT_BITS = 8;
  parameter int NIB_W     = 4;
  parameter int DATA_W    = 8;
  localparam int ADDR_W   = $clog2(SLOTS);
  localparam int BIT_W    = $clog2(SLOT_BITS);
endpackage

// File: rtl/sigbuf_slot_ctr.sv
module sigbuf_slot_ctr
  import sigbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              e1_mode_i,
  output logic              cap_o,
  output logic [ADDR_W-1:0] slot_o
);
  logic              active_q;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] slot_q;
  logic [ADDR_W-1:0] last_slot;
  logic              slot_end;

  assign last_slot = e1_mode_i ? ADDR_W'(SLOTS - 1) : ADDR_W'(T1_SLOTS - 1);
  assign slot_end  = (bit_q == BIT_W'(SLOT_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (fsync_i) begin
      // sync cycle is bit 0 of slot 0
      active_q <= 1'b1;
      bit_q    <= BIT_W'(1);
      slot_q   <= '0;
    end else if (active_q) begin
      bit_q <= bit_q + BIT_W'(1);
      if (slot_end) begin
        if (slot_q >= last_slot) active_q <= 1'b0;
        else                     slot_q   <= slot_q + ADDR_W'(1);
      end
    end
  end

  assign cap_o  = active_q && slot_end && !fsync_i;
  assign slot_o = slot_q;
endmodule

// File: rtl/sigbuf_shift.sv
module sigbuf_shift
  import sigbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  output logic [NIB_W-1:0] nib_o
);
  logic [NIB_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[NIB_W-3:0], sig_i};
  end

  // current bit completes the nibble
  assign nib_o = {sh_q, sig_i};
endmodule

// File: rtl/sigbuf_store.sv
module sigbuf_store
  import sigbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] slot_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  logic [NIB_W-1:0] mem_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[i] <= '0;
      else if (cpu_we_i && cpu_addr_i == ADDR_W'(i))
        mem_q[i] <= cpu_wdata_i[NIB_W-1:0];
      else if (cap_i && slot_i == ADDR_W'(i))
        mem_q[i] <= nib_i;
    end
  end

  assign cpu_rdata_o = {{(DATA_W - NIB_W){1'b0}}, mem_q[cpu_addr_i]};
endmodule

// File: rtl/sig_capture_buf.sv
module sig_capture_buf
  import sigbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,
  input  logic              fsync_i,
  input  logic              e1_mode_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  logic              cap;
  logic [ADDR_W-1:0] slot;
  logic [NIB_W-1:0]  nib;

  sigbuf_slot_ctr i_ctr (
    .clk_i, .rst_ni, .fsync_i, .e1_mode_i,
    .cap_o  (cap),
    .slot_o (slot)
  );

  sigbuf_shift i_shift (
    .clk_i, .rst_ni, .sig_i,
    .nib_o (nib)
  );

  sigbuf_store i_store (
    .clk_i, .rst_ni,
    .cap_i  (cap),
    .slot_i (slot),
    .nib_i  (nib),
    .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_rdata_o
  );
endmodule

// File: rtl/sigbuf_chk.sv
module sigbuf_chk
  import sigbuf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_i,
  input logic              e1_mode_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              cap_i,
  input logic [ADDR_W-1:0] slot_i,
  input logic [NIB_W-1:0]  nib_i
);
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rdata_o[DATA_W-1:NIB_W] == '0);

  p_t1_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !e1_mode_i |-> slot_i < ADDR_W'(T1_SLOTS));

  p_cap_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> !cap_i);

  p_sync_no_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |-> !cap_i);

  p_cpu_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |=> (cpu_addr_i != $past(cpu_addr_i)) ||
                 (cpu_rdata_o[NIB_W-1:0] == $past(cpu_wdata_i[NIB_W-1:0])));

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !(cpu_we_i && cpu_addr_i == slot_i) |=>
      (cpu_addr_i != $past(slot_i)) || (cpu_rdata_o[NIB_W-1:0] == $past(nib_i)));
endmodule

bind sig_capture_buf sigbuf_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fsync_i     (fsync_i),
  .e1_mode_i   (e1_mode_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_rdata_o (cpu_rdata_o),
  .cap_i       (cap),
  .slot_i      (slot),
  .nib_i       (nib)
);

// File: tb/test_sig_capture_buf.sv
`timescale 1ns/1ps
module test_sig_capture_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sig_i = 1'b0;
  logic       fsync_i = 1'b0;
  logic       e1_mode_i = 1'b1;
  logic       cpu_we_i = 1'b0;
  logic [4:0] cpu_addr_i = '0;
  logic [7:0] cpu_wdata_i = '0;
  logic [7:0] cpu_rdata_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q [32];

  always #2 clk_i = ~clk_i;

  sig_capture_buf i_sig_capture_buf (.*);

  function automatic logic [7:0] byte_of(int seed, int s);
    return 8'(seed * 37 + s * 29 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk_i);
      cpu_addr_i = 5'(a);
      #1;
      chk(cpu_rdata_o === {4'b0, exp_q[a]}, req, cpu_rdata_o, {4'b0, exp_q[a]});
    end
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      fsync_i = 1'b0;
      sig_i   = 1'(i ^ (i >> 2));
    end
  endtask

  task automatic cpu_write(input int a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_we_i = 1'b1; cpu_addr_i = 5'(a); cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
    exp_q[a] = d[3:0];
  endtask

  // one frame; optional collision write and end-of-slot watch
  task automatic run_frame(input bit e1, input int seed, input int coll_slot,
                           input logic [7:0] coll_val, input int watch_slot);
    int n;
    logic [7:0] b8;
    n = e1 ? 32 : 24;
    e1_mode_i = e1;
    for (int s = 0; s < n; s++) begin
      b8 = byte_of(seed, s);
      for (int b = 0; b < 8; b++) begin
        @(negedge clk_i);
        fsync_i  = (s == 0 && b == 0);
        sig_i    = b8[7-b];
        cpu_we_i = 1'b0;
        if (watch_slot >= 0) cpu_addr_i = 5'(watch_slot);
        if (s == coll_slot && b == 7) begin
          cpu_we_i = 1'b1; cpu_addr_i = 5'(s); cpu_wdata_i = coll_val;
        end
        if (s == watch_slot && b == 7) begin
          #1 chk(cpu_rdata_o === {4'b0, exp_q[s]}, "R4 old value at last bit",
                 cpu_rdata_o, {4'b0, exp_q[s]});
        end
        if (watch_slot >= 0 && s == watch_slot + 1 && b == 0) begin
          #1 chk(cpu_rdata_o === {4'b0, byte_of(seed, watch_slot)[3:0]},
                 "R4 new value after slot", cpu_rdata_o,
                 {4'b0, byte_of(seed, watch_slot)[3:0]});
        end
      end
    end
    @(negedge clk_i);
    fsync_i = 1'b0; cpu_we_i = 1'b0; sig_i = 1'b1;  // T1 framing bit / idle
    for (int s = 0; s < n; s++)
      exp_q[s] = (s == coll_slot) ? coll_val[3:0] : byte_of(seed, s)[3:0];
  endtask

  initial begin
    for (int i = 0; i < 32; i++) exp_q[i] = '0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    check_all("R1 reset value");
    junk(100);
    check_all("R7 no capture before first sync");
    run_frame(1'b1, 1, -1, 8'h00, 5);
    check_all("R5 E1 frame");
    junk(40);
    check_all("R7 idle after last slot");
    for (int a = 24; a < 32; a++) cpu_write(a, 8'(a * 7) ^ 8'hC0);
    check_all("R9 cpu write");
    run_frame(1'b0, 2, -1, 8'h00, 23);
    check_all("R6 T1 frame keeps 24..31");
    run_frame(1'b1, 3, 10, 8'hA5, -1);
    check_all("R10 cpu wins collision");
    e1_mode_i = 1'b1;
    @(negedge clk_i); fsync_i = 1'b1; sig_i = 1'b0;
    junk(20);
    run_frame(1'b1, 4, -1, 8'h00, -1);
    check_all("R8 realign on early sync");
    for (int k = 5; k < 13; k++) begin
      run_frame(k[0], k, -1, 8'h00, k);
      check_all("R3 slot alignment sweep");
    end
    run_frame(1'b0, 20, 23, 8'h3F, -1);
    check_all("R10 collision on last T1 slot");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule